// File: doc/BRIEF.md
# Serial Flash Status Poller

This block keeps asking an external serial flash for its status byte until that byte shows the state software is waiting for, such as a write-in-progress bit going low. Software sets a target value, a bit mask, a compare mode, a gap between reads, the flash size and a start address, and then pulses `start`. The poller issues a status-read command to a serial sequencer through a request/response handshake. It stores every returned byte and tests the byte under the mask. When the test succeeds it sets a sticky match flag, and it can also return to idle by itself.

Before polling begins, the programmed address is compared with the configured flash size. An address that lies beyond the device produces a sticky error flag in place of a command. The match flag and the error flag each feed the single interrupt output through their own enable. Software clears the flags by writing ones to the clear input. A `start` pulse that arrives while polling is active is dropped, and `abort` returns the block to idle at any time.

Top module: `flash_status_poller`

## Requirements
- R1: While reset is held, and afterwards until the first start, `busy`, `cmd_req`, `match_flag`, `err_flag` and `irq` are 0 and `status_data` is 0x00.
- R2: When `start` is sampled high while idle and the address is in range, `cmd_req` goes to 1 in the next cycle with `cmd_addr` equal to `cfg_addr`. It stays at 1 until the cycle in which `rsp_valid` is high.
- R3: Every `rsp_data` byte accepted with `rsp_valid` while `cmd_req` is high appears on `status_data` in the next cycle, whether or not it matches, and it is held there until the next accepted response.
- R4: With `cfg_or_mode` = 0, a response matches when every bit set in `cfg_mask` is equal to the same bit of `cfg_match_val`. A mask of 0x00 therefore always matches. A match sets `match_flag`.
- R5: With `cfg_or_mode` = 1, a response matches when at least one bit set in `cfg_mask` is equal to the same bit of `cfg_match_val`. A mask of 0x00 therefore never matches.
- R6: If a response matches and `cfg_auto_stop` = 1, `busy` is 0 in the next cycle and no further command is issued. If `cfg_auto_stop` = 0, polling continues after a match.
- R7: After each response that does not stop polling, `cmd_req` stays at 0 for exactly `cfg_interval`+1 cycles and then rises again.
- R8: The flash holds 2^(`cfg_fsize`+1) bytes. A start with `cfg_addr` at or above that limit sets `err_flag` in the next cycle, issues no command and leaves `busy` at 0. With `cfg_fsize` = 31, every address is in range.
- R9: `irq` is (`match_flag` AND `cfg_match_ie`) OR (`err_flag` AND `cfg_err_ie`).
- R10: In `flag_clr`, bit 0 clears `match_flag` and bit 1 clears `err_flag` in the next cycle. A bit written as 0 leaves its flag unchanged.
- R11: A `start` pulse while `busy` is 1 is ignored. It does not restart the interval count and does not load a new `cmd_addr`.
- R12: `abort` makes `busy` and `cmd_req` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_match_val | input | 8 | Target status value |
| cfg_mask | input | 8 | Bits taking part in the compare |
| cfg_or_mode | input | 1 | 0: all masked bits must be equal, 1: any one masked bit equal is enough |
| cfg_interval | input | 16 | Idle cycles between reads, minus one |
| cfg_auto_stop | input | 1 | Stop polling on a match |
| cfg_match_ie | input | 1 | Interrupt enable for the match flag |
| cfg_err_ie | input | 1 | Interrupt enable for the error flag |
| cfg_fsize | input | 5 | Flash size code, 2^(n+1) bytes |
| cfg_addr | input | 32 | Address sent with the command |
| start | input | 1 | Begin polling (pulse) |
| abort | input | 1 | Return to idle |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 match, bit 1 error |
| cmd_req | output | 1 | Status-read request to the sequencer |
| cmd_addr | output | 32 | Address latched at start |
| rsp_valid | input | 1 | Sequencer returns a status byte |
| rsp_data | input | 8 | Returned status byte |
| busy | output | 1 | Polling active |
| status_data | output | 8 | Last status byte received |
| match_flag | output | 1 | Sticky match flag |
| err_flag | output | 1 | Sticky address-range error flag |
| irq | output | 1 | Interrupt |

## Verification
The bench drives both compare modes with a mask of 0x00. A design that handled the empty mask incorrectly would stop polling in OR mode, or would poll forever in AND mode. It places the address exactly at the size limit and one below it, and it uses the largest size code. An off-by-one error or a shift overflow in the limit would then reject a good address or accept a bad one. It measures the gap between reads at interval 0 and interval 3, and it pulses `start` in the middle of a gap. A gap of the wrong length, or a command that was re-armed by that pulse, shows up as a wrong count of idle cycles or as a changed `cmd_addr`. It also clears one flag alone to show that the two clear bits act independently.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } fsp_state_e;
endpackage

// File: rtl/fsp_range_chk.sv
module fsp_range_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] fsize,
  output logic              out_of_range
);
  logic [SIZE_W:0] shamt;
  logic [ADDR_W:0] upper;

  always_comb begin
    shamt        = {1'b0, fsize} + {{SIZE_W{1'b0}}, 1'b1};
    upper        = {1'b0, addr} >> shamt;
    out_of_range = |upper;
  end
endmodule

// File: rtl/fsp_match.sv
module fsp_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] target,
  input  logic [DATA_W-1:0] mask,
  input  logic              any_mode,
  output logic              hit
);
  logic [DATA_W-1:0] equal_bits;

  always_comb begin
    equal_bits = ~(data ^ target);
    if (any_mode) hit = |(equal_bits & mask);
    else          hit = &(equal_bits | ~mask);
  end
endmodule

// File: rtl/fsp_gap_timer.sv
module fsp_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
    done   = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_match_val,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              cfg_or_mode,
  input  logic [CNT_W-1:0]  cfg_interval,
  input  logic              cfg_auto_stop,
  input  logic              cfg_match_ie,
  input  logic              cfg_err_ie,
  input  logic [SIZE_W-1:0] cfg_fsize,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              start,
  input  logic              abort,
  input  logic [1:0]        flag_clr,
  output logic              cmd_req,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic [DATA_W-1:0] status_data,
  output logic              match_flag,
  output logic              err_flag,
  output logic              irq
);
  localparam int CLR_MATCH = 0;
  localparam int CLR_ERR   = 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fsp_state_e        state_q, state_d;
  logic              match_q, match_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] stat_q, stat_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_bad, hit, tmr_load, tmr_done, accept;

  fsp_range_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_range (
    .addr(cfg_addr), .fsize(cfg_fsize), .out_of_range(addr_bad)
  );

  fsp_match #(.DATA_W(DATA_W)) u_match (
    .data(rsp_data), .target(cfg_match_val), .mask(cfg_mask),
    .any_mode(cfg_or_mode), .hit(hit)
  );

  fsp_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load), .load_val(cfg_interval),
    .run(state_q == ST_WAIT), .done(tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    match_d  = match_q;
    err_d    = err_q;
    stat_d   = stat_q;
    addr_d   = addr_q;
    tmr_load = 1'b0;
    accept   = (state_q == ST_ISSUE) && rsp_valid;
    if (flag_clr[CLR_MATCH]) match_d = 1'b0;
    if (flag_clr[CLR_ERR])   err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (addr_bad) begin
            err_d = 1'b1;
          end else begin
            state_d = ST_ISSUE;
            addr_d  = cfg_addr;
          end
        end
      end
      ST_ISSUE: begin
        if (rsp_valid) begin
          stat_d = rsp_data;
          if (hit) match_d = 1'b1;
          if (hit && cfg_auto_stop) begin
            state_d = ST_IDLE;
          end else begin
            state_d  = ST_WAIT;
            tmr_load = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (tmr_done) state_d = ST_ISSUE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      match_q <= 1'b0;
      err_q   <= 1'b0;
      stat_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      match_q <= match_d;
      err_q   <= err_d;
      if (accept) stat_q <= stat_d;
      if ((state_q == ST_IDLE) && start && !addr_bad) addr_q <= addr_d;
    end
  end

  assign cmd_req     = (state_q == ST_ISSUE);
  assign busy        = (state_q != ST_IDLE);
  assign cmd_addr    = addr_q;
  assign status_data = stat_q;
  assign match_flag  = match_q;
  assign err_flag    = err_q;
  assign irq         = (match_q & cfg_match_ie) | (err_q & cfg_err_ie);

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_req |-> busy); // R2
  AST_RSP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_req && rsp_valid) |=> (status_data == $past(rsp_data))); // R3
  AST_BAD_ADDR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && start && addr_bad && !flag_clr[CLR_ERR]) |=> (!cmd_req && err_flag)); // R8
  AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_req && rsp_valid && hit && cfg_auto_stop) |=> !busy); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (match_flag || err_flag)); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    abort |=> !busy); // R12
endmodule

// File: tb/flash_status_poller_tb.sv
module flash_status_poller_tb;
  logic        clk, rst_n;
  logic [7:0]  cfg_match_val, cfg_mask;
  logic        cfg_or_mode, cfg_auto_stop, cfg_match_ie, cfg_err_ie;
  logic [15:0] cfg_interval;
  logic [4:0]  cfg_fsize;
  logic [31:0] cfg_addr;
  logic        start, abort, rsp_valid;
  logic [1:0]  flag_clr;
  logic [7:0]  rsp_data;
  logic        cmd_req, busy, match_flag, err_flag, irq;
  logic [31:0] cmd_addr;
  logic [7:0]  status_data;
  int checks = 0;
  int errors = 0;

  flash_status_poller u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_match_val(cfg_match_val), .cfg_mask(cfg_mask),
    .cfg_or_mode(cfg_or_mode), .cfg_interval(cfg_interval), .cfg_auto_stop(cfg_auto_stop),
    .cfg_match_ie(cfg_match_ie), .cfg_err_ie(cfg_err_ie), .cfg_fsize(cfg_fsize),
    .cfg_addr(cfg_addr), .start(start), .abort(abort), .flag_clr(flag_clr),
    .cmd_req(cmd_req), .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .status_data(status_data), .match_flag(match_flag),
    .err_flag(err_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // mask, match value, or-mode, response, expected match
  localparam logic [25:0] VEC [8] = '{
    {8'hFF, 8'hA5, 1'b0, 8'hA5, 1'b1},
    {8'hFF, 8'hA5, 1'b0, 8'hA4, 1'b0},
    {8'h01, 8'h00, 1'b0, 8'hFE, 1'b1},
    {8'h00, 8'hFF, 1'b0, 8'h00, 1'b1},
    {8'h0F, 8'h0F, 1'b1, 8'h01, 1'b1},
    {8'h0F, 8'h0F, 1'b1, 8'hF0, 1'b0},
    {8'h00, 8'h00, 1'b1, 8'h00, 1'b0},
    {8'h80, 8'h00, 1'b1, 8'h7F, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic respond(input logic [7:0] d);
    rsp_valid = 1'b1; rsp_data = d; tick(); rsp_valid = 1'b0;
  endtask

  task automatic go_idle();
    abort = 1'b1; flag_clr = 2'b11; tick(); abort = 1'b0; flag_clr = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; abort = 0; flag_clr = 0; rsp_valid = 0; rsp_data = 0;
    cfg_match_val = 0; cfg_mask = 0; cfg_or_mode = 0; cfg_interval = 0;
    cfg_auto_stop = 1; cfg_match_ie = 0; cfg_err_ie = 0; cfg_fsize = 5'd9; cfg_addr = 0;
    repeat (3) tick();
    check("R1 busy", busy, 0); check("R1 cmd_req", cmd_req, 0);
    check("R1 match_flag", match_flag, 0); check("R1 err_flag", err_flag, 0);
    check("R1 status_data", status_data, 0);
    rst_n = 1'b1;
    repeat (5) tick();
    check("R1 irq after reset", irq, 0);

    for (int i = 0; i < 8; i++) begin
      cfg_mask = VEC[i][25:18]; cfg_match_val = VEC[i][17:10];
      cfg_or_mode = VEC[i][9];
      do_start();
      check("R2 req", cmd_req, 1);
      respond(VEC[i][8:1]);
      check("R3 status kept", status_data, VEC[i][8:1]);
      check(cfg_or_mode ? "R5 or-mode match" : "R4 and-mode match", match_flag, VEC[i][0]);
      check("R6 auto stop", busy, !VEC[i][0]);
      go_idle();
      check("R10 flags cleared", match_flag, 0);
      check("R12 abort idle", busy, 0);
    end

    // R2 / R7 / R11: hold, gap length, start ignored while busy
    cfg_mask = 8'hFF; cfg_match_val = 8'h00; cfg_or_mode = 0; cfg_auto_stop = 0;
    cfg_interval = 16'd3; cfg_addr = 32'h123;
    do_start();
    check("R2 addr", cmd_addr, 32'h123);
    repeat (3) tick();
    check("R2 req held", cmd_req, 1);
    cfg_addr = 32'h55;
    do_start();
    check("R11 addr not reloaded", cmd_addr, 32'h123);
    respond(8'h3C);
    begin
      int n = 0;
      while (!cmd_req && n < 50) begin
        start = (n == 2);
        n++; tick();
      end
      start = 1'b0;
      check("R7 R11 gap interval 3", n, 4);
    end
    check("R3 last value", status_data, 8'h3C);
    check("R11 addr after gap", cmd_addr, 32'h123);
    cfg_interval = 16'd0;
    respond(8'h3D);
    begin
      int n = 0;
      while (!cmd_req && n < 50) begin n++; tick(); end
      check("R7 gap interval 0", n, 1);
    end
    // R6: match without auto stop keeps polling
    cfg_match_val = 8'h3E; cfg_interval = 16'd2;
    respond(8'h3E);
    check("R6 no auto stop busy", busy, 1);
    check("R4 match set", match_flag, 1);
    check("R9 irq masked", irq, 0);
    cfg_match_ie = 1'b1; #1;
    check("R9 match irq", irq, 1);
    flag_clr = 2'b10; tick(); flag_clr = 2'b00;
    check("R10 match kept", match_flag, 1);
    begin
      int n = 0;
      while (!cmd_req && n < 50) begin n++; tick(); end
      check("R6 R7 polling resumes", n, 2);
    end
    abort = 1'b1; tick(); abort = 1'b0;
    check("R12 req dropped", cmd_req, 0);
    check("R12 busy dropped", busy, 0);
    flag_clr = 2'b01; tick(); flag_clr = 2'b00;
    check("R10 match cleared", match_flag, 0);
    cfg_match_ie = 1'b0;

    // R8: range limit 2^(9+1) = 1024
    cfg_fsize = 5'd9; cfg_addr = 32'd1024;
    do_start();
    check("R8 err at limit", err_flag, 1);
    check("R8 no busy", busy, 0);
    check("R8 no req", cmd_req, 0);
    check("R9 err irq masked", irq, 0);
    cfg_err_ie = 1'b1; #1;
    check("R9 err irq", irq, 1);
    flag_clr = 2'b10; tick(); flag_clr = 2'b00;
    check("R10 err cleared", err_flag, 0);
    check("R9 irq cleared", irq, 0);
    cfg_addr = 32'd1023;
    do_start();
    check("R8 below limit busy", busy, 1);
    check("R8 below limit no err", err_flag, 0);
    abort = 1'b1; tick(); abort = 1'b0;
    cfg_fsize = 5'd31; cfg_addr = 32'hFFFF_FFFF;
    do_start();
    check("R8 full size busy", busy, 1);
    check("R8 full size no err", err_flag, 0);
    check("R2 full size addr", cmd_addr, 32'hFFFF_FFFF);
    abort = 1'b1; tick(); abort = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule